// File: doc/BRIEF.md
# SPI Serial EEPROM Slave Model

This block is a synthesizable behavioural model of a 512-byte serial EEPROM that answers on an SPI bus in mode 0. It is used as the far-end device when verifying an SPI master controller, either in simulation or on an emulation board. It runs on a system clock that is much faster than the serial clock. It oversamples the select, serial clock, data-in, write-protect and pause inputs through a synchronizer, finds the serial clock edges, and drives the serial data output from a register.

The first byte of every transaction is the command. For reads and writes, the command byte also carries the ninth address bit, and the byte that follows gives the low eight address bits. Reads stream bytes for as long as select stays low. Writes gather up to one page of data in a buffer, and that buffer is committed to the array only when select rises on a byte boundary. After a memory or status write, the model holds a busy flag for a set number of system clock cycles, and the master must poll for its end. A write-enable latch and two block-protect bits gate every change to the array and to the status register.

Top module: `spi_eeprom_model`

## Requirements
- R1: Only these command bytes are acted on: 0x05 status read, 0x06 write enable, 0x01 status write, 0000_A_011 read and 0000_A_010 write, where bit 3 (A) is address bit 8. Any other command byte leaves memory and status unchanged, and `miso` stays high for the rest of that transaction.
- R2: The status byte is {4'b0000, protect[1:0], wel, busy}. Bit 0 is busy, bit 1 is the write-enable latch, bits 3:2 are the protect bits, and after reset it reads 0x00.
- R3: Data is taken from `mosi` on the rising edge of `spi_clk`, MSB first. The next output bit appears on `miso` after a falling edge. A read returns the byte at {A, address byte} and then keeps returning successive bytes, with the address wrapping from 0x1FF to 0x000. `miso` is high while the device is deselected.
- R4: A write-enable command sets the latch when select rises after a whole number of bytes.
- R5: Memory writes and status writes issued while the latch is clear are discarded. They leave memory and status unchanged and do not start a busy period.
- R6: During a write, the address advances after each data byte and wraps within its 16-byte page. Bytes are written only when select rises on a byte boundary.
- R7: An accepted memory or status write sets busy when select rises, clears the latch at the same moment, and keeps busy set for BUSY_CYCLES system clocks.
- R8: While busy is set, every command other than status read is ignored. This includes read, write and write enable.
- R9: The protect bits guard part of the array: 01 guards 0x180-0x1FF, 10 guards 0x100-0x1FF and 11 guards all of it. Bytes written into a guarded region are dropped.
- R10: If select rises in the middle of a byte, the command is abandoned. Memory, the protect bits and the latch all stay unchanged.
- R11: A status write changes only the protect bits (bits 3:2). It is discarded while `wr_prot_n` is low, and in that case the latch stays set and busy stays clear.
- R12: While `pause_n` is low, `spi_clk` edges are ignored, and the transaction resumes where it stopped once `pause_n` goes high again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the serial bus |
| rst_n | input | 1 | Active-low asynchronous reset; the array returns to the erased value |
| spi_clk | input | 1 | Serial clock from the master, idle low |
| sel_n | input | 1 | Active-low device select |
| mosi | input | 1 | Serial data from the master |
| wr_prot_n | input | 1 | Active-low guard on status writes |
| pause_n | input | 1 | Active-low pause; freezes the transaction |
| miso | output | 1 | Serial data to the master |

## Verification
Most internal faults in this model become visible through a status read or a read-back. A wrong latch, protect field or busy counter is reported in the very next status byte, which is loaded at the rising edge that completes the command byte. A wrong address counter, page wrap or guard decision only appears when the affected byte is read back, so the bench reads every written address and its neighbours after each write. A fault in the serial shifter itself corrupts `miso` within one byte time, and each expected bit is sampled half an `spi_clk` period after the falling edge that launched it.

// File: rtl/spi_ee_pkg.sv
package spi_ee_pkg;
   localparam int ADDR_W = 9;
   localparam int DEPTH  = 1 << ADDR_W;

   localparam logic [7:0] CMD_STAT_RD = 8'h05;
   localparam logic [7:0] CMD_WR_EN   = 8'h06;
   localparam logic [7:0] CMD_STAT_WR = 8'h01;
   localparam logic [2:0] CMD_RD_LOW  = 3'b011;
   localparam logic [2:0] CMD_WR_LOW  = 3'b010;

   typedef enum logic [2:0] {
      PH_CMD,
      PH_ADDR,
      PH_RDATA,
      PH_WDATA,
      PH_SDATA,
      PH_STAT,
      PH_ARM,
      PH_SKIP
   } phase_t;
endpackage

// File: rtl/spi_ee_sync.sv
module spi_ee_sync #(
   parameter int W = 1,
   parameter int STAGES = 2,
   parameter logic [W-1:0] RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] d_o
);
   generate
      if (STAGES == 0) begin : g_pass
         assign d_o = d_i;
      end else begin : g_chain
         logic [W-1:0] st [STAGES];
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int k = 0; k < STAGES; k++) st[k] <= RST_VAL;
            end else begin
               st[0] <= d_i;
               for (int k = 1; k < STAGES; k++) st[k] <= st[k-1];
            end
         end
         assign d_o = st[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/spi_ee_busy.sv
module spi_ee_busy #(
   parameter int CYCLES = 1000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic busy
);
   localparam int CW = $clog2(CYCLES + 1);

   generate
      if (CYCLES < 1) begin : g_bad_cycles
         $error("busy period must be at least one cycle");
      end
   endgenerate

   logic [CW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              cnt <= '0;
      else if (start)          cnt <= CW'(CYCLES);
      else if (cnt != '0)      cnt <= cnt - CW'(1);
   end

   assign busy = (cnt != '0);

   // R7
   busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> busy);
   // R7
   busy_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(start));
endmodule

// File: rtl/spi_ee_mem.sv
module spi_ee_mem
   import spi_ee_pkg::*;
#(
   parameter int PAGE_BYTES = 16,
   parameter logic [7:0] ERASED_VAL = 8'hFF
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          we,
   input  logic [ADDR_W-$clog2(PAGE_BYTES)-1:0] base,
   input  logic [PAGE_BYTES-1:0][7:0]    wdata,
   input  logic [PAGE_BYTES-1:0]         wmask,
   input  logic [ADDR_W-1:0]             raddr,
   output logic [7:0]                    rdata
);
   localparam int PW = $clog2(PAGE_BYTES);

   generate
      if (PAGE_BYTES >= DEPTH) begin : g_bad_page
         $error("page must be smaller than the array");
      end
   endgenerate

   logic [7:0] mem [DEPTH];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) mem[i] <= ERASED_VAL;
      end else if (we) begin
         for (int j = 0; j < PAGE_BYTES; j++)
            if (wmask[j]) mem[{base, PW'(j)}] <= wdata[j];
      end
   end

   assign rdata = mem[raddr];
endmodule

// File: rtl/spi_eeprom_model.sv
module spi_eeprom_model
   import spi_ee_pkg::*;
#(
   parameter int PAGE_BYTES  = 16,
   parameter int BUSY_CYCLES = 1000,
   parameter int SYNC_STAGES = 2,
   parameter logic [7:0] ERASED_VAL = 8'hFF
) (
   input  logic clk,
   input  logic rst_n,
   input  logic spi_clk,
   input  logic sel_n,
   input  logic mosi,
   input  logic wr_prot_n,
   input  logic pause_n,
   output logic miso
);
   localparam int PW = $clog2(PAGE_BYTES);
   localparam int BW = ADDR_W - PW;

   generate
      if (PAGE_BYTES < 2 || PAGE_BYTES > 256 || (PAGE_BYTES & (PAGE_BYTES - 1)) != 0) begin : g_bad_pg
         $error("page size must be a power of two from 2 to 256");
      end
      if (SYNC_STAGES < 0 || SYNC_STAGES > 3) begin : g_bad_sync
         $error("synchronizer depth must be 0 to 3");
      end
   endgenerate

   // input conditioning
   logic sck_s, csn_s, si_s, wpn_s, holdn_s;
   spi_ee_sync #(.W(5), .STAGES(SYNC_STAGES), .RST_VAL(5'b01011)) u_sync (
      .clk(clk), .rst_n(rst_n),
      .d_i({spi_clk, sel_n, mosi, wr_prot_n, pause_n}),
      .d_o({sck_s, csn_s, si_s, wpn_s, holdn_s})
   );

   logic sck_q, csn_q;
   logic sck_rise, sck_fall, cs_rise;
   assign sck_rise = sck_s & ~sck_q & ~csn_s & holdn_s;
   assign sck_fall = ~sck_s & sck_q & ~csn_s & holdn_s;
   assign cs_rise  = csn_s & ~csn_q;

   // transaction state
   phase_t              phase;
   logic [2:0]          bit_cnt;
   logic [6:0]          rx_sr;
   logic [7:0]          rx_byte;
   logic                a8, rd_cmd;
   logic [ADDR_W-1:0]   addr, addr_in, rd_addr;
   logic [PW-1:0]       woff;
   logic [BW-1:0]       pbase;
   logic [PAGE_BYTES-1:0][7:0] pbuf;
   logic [PAGE_BYTES-1:0] pmask, keep;
   logic [1:0]          bp, sr_bp;
   logic                sr_full, wel;
   logic [7:0]          tx_sr, stat_byte, rd_data;
   logic                so_r, busy;
   logic                arm_ok, wr_ok, sr_ok, mem_we, busy_go;

   assign rx_byte   = {rx_sr, si_s};
   assign addr_in   = {a8, rx_byte};
   assign rd_addr   = (phase == PH_ADDR) ? addr_in : addr + ADDR_W'(1);
   assign stat_byte = {4'b0000, bp, wel, busy};

   assign arm_ok  = (phase == PH_ARM)   && (bit_cnt == 3'd0);
   assign wr_ok   = (phase == PH_WDATA) && (bit_cnt == 3'd0) && (pmask != '0);
   assign sr_ok   = sr_full && (bit_cnt == 3'd0) && wpn_s;
   assign mem_we  = cs_rise & wr_ok;
   assign busy_go = cs_rise & (wr_ok | sr_ok);

   function automatic logic guarded(input logic [1:0] b, input logic [ADDR_W-1:0] a);
      case (b)
         2'b00:   guarded = 1'b0;
         2'b01:   guarded = (a[ADDR_W-1 -: 2] == 2'b11);
         2'b10:   guarded = a[ADDR_W-1];
         default: guarded = 1'b1;
      endcase
   endfunction

   for (genvar g = 0; g < PAGE_BYTES; g++) begin : g_guard
      assign keep[g] = pmask[g] & ~guarded(bp, {pbase, PW'(g)});
   end

   spi_ee_mem #(.PAGE_BYTES(PAGE_BYTES), .ERASED_VAL(ERASED_VAL)) u_mem (
      .clk(clk), .rst_n(rst_n), .we(mem_we), .base(pbase),
      .wdata(pbuf), .wmask(keep), .raddr(rd_addr), .rdata(rd_data)
   );

   spi_ee_busy #(.CYCLES(BUSY_CYCLES)) u_busy (
      .clk(clk), .rst_n(rst_n), .start(busy_go), .busy(busy)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sck_q <= 1'b0;  csn_q <= 1'b1;
         phase <= PH_CMD; bit_cnt <= '0; rx_sr <= '0;
         a8 <= 1'b0; rd_cmd <= 1'b0; addr <= '0;
         woff <= '0; pbase <= '0; pbuf <= '0; pmask <= '0;
         bp <= '0; sr_bp <= '0; sr_full <= 1'b0; wel <= 1'b0;
         tx_sr <= 8'hFF; so_r <= 1'b1;
      end else begin
         sck_q <= sck_s;
         csn_q <= csn_s;
         if (csn_s) begin
            phase <= PH_CMD; bit_cnt <= '0; rx_sr <= '0;
            pmask <= '0; sr_full <= 1'b0;
            tx_sr <= 8'hFF; so_r <= 1'b1;
            if (cs_rise) begin
               if (arm_ok) wel <= 1'b1;
               if (wr_ok)  wel <= 1'b0;
               if (sr_ok) begin
                  wel <= 1'b0;
                  bp  <= sr_bp;
               end
            end
         end else begin
            if (sck_rise) begin
               bit_cnt <= bit_cnt + 3'd1;
               rx_sr   <= rx_byte[6:0];
               if (bit_cnt == 3'd7) begin
                  case (phase)
                     PH_CMD: begin
                        if (rx_byte == CMD_STAT_RD) begin
                           phase <= PH_STAT;
                           tx_sr <= stat_byte;
                        end else if (busy) begin
                           phase <= PH_SKIP;
                        end else if (rx_byte == CMD_WR_EN) begin
                           phase <= PH_ARM;
                        end else if (rx_byte == CMD_STAT_WR) begin
                           phase <= wel ? PH_SDATA : PH_SKIP;
                        end else if (rx_byte[7:4] == 4'd0 && rx_byte[2:0] == CMD_RD_LOW) begin
                           a8 <= rx_byte[3]; rd_cmd <= 1'b1; phase <= PH_ADDR;
                        end else if (rx_byte[7:4] == 4'd0 && rx_byte[2:0] == CMD_WR_LOW && wel) begin
                           a8 <= rx_byte[3]; rd_cmd <= 1'b0; phase <= PH_ADDR;
                        end else begin
                           phase <= PH_SKIP;
                        end
                     end
                     PH_ADDR: begin
                        if (rd_cmd) begin
                           addr  <= addr_in;
                           tx_sr <= rd_data;
                           phase <= PH_RDATA;
                        end else begin
                           pbase <= addr_in[ADDR_W-1:PW];
                           woff  <= addr_in[PW-1:0];
                           phase <= PH_WDATA;
                        end
                     end
                     PH_RDATA: begin
                        addr  <= rd_addr;
                        tx_sr <= rd_data;
                     end
                     PH_WDATA: begin
                        pbuf[woff]  <= rx_byte;
                        pmask[woff] <= 1'b1;
                        woff        <= woff + PW'(1);
                     end
                     PH_SDATA: begin
                        sr_bp   <= rx_byte[3:2];
                        sr_full <= 1'b1;
                        phase   <= PH_SKIP;
                     end
                     PH_STAT: tx_sr <= stat_byte;
                     default: ;
                  endcase
               end
            end
            if (sck_fall) begin
               so_r  <= tx_sr[7];
               tx_sr <= {tx_sr[6:0], 1'b1};
            end
         end
      end
   end

   assign miso = so_r;

   // R5
   wel_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |-> wel);
   // R8
   busy_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |-> !busy);
   // R12
   pause_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!holdn_s && !csn_s) |=> $stable(bit_cnt));
   // R4
   wel_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(wel) |-> $past(cs_rise));
   // R10
   abort_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cs_rise && bit_cnt != 3'd0) |=> $stable(bp));
endmodule

// File: tb/sim_spi_eeprom_model.sv
module sim_spi_eeprom_model;
   localparam int CLK_NS = 10;
   localparam int HALF   = 6;

   logic clk = 1'b0, rst_n = 1'b0;
   logic spi_clk = 1'b0, sel_n = 1'b1, mosi = 1'b0, wr_prot_n = 1'b1, pause_n = 1'b1;
   logic miso;
   int checks = 0, errors = 0;

   always #(CLK_NS/2) clk = ~clk;

   spi_eeprom_model u0 (
      .clk(clk), .rst_n(rst_n), .spi_clk(spi_clk), .sel_n(sel_n),
      .mosi(mosi), .wr_prot_n(wr_prot_n), .pause_n(pause_n), .miso(miso)
   );

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic chk(input string what, input logic [7:0] got, input logic [7:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s: got %02h expected %02h", what, got, exp);
      end
   endtask

   task automatic bits(input logic [7:0] tx, input int n, output logic [7:0] rx);
      rx = 8'h00;
      for (int i = 7; i > 7 - n; i--) begin
         mosi = tx[i];
         idle(HALF);
         rx[i] = miso;
         spi_clk = 1'b1;
         idle(HALF);
         spi_clk = 1'b0;
      end
   endtask

   task automatic xfer(input logic [7:0] tx, output logic [7:0] rx);
      bits(tx, 8, rx);
   endtask

   task automatic sel();
      sel_n = 1'b0;
      idle(HALF);
   endtask

   task automatic desel();
      idle(HALF);
      sel_n = 1'b1;
      idle(4 * HALF);
   endtask

   task automatic rdsr(output logic [7:0] s);
      logic [7:0] d;
      sel(); xfer(8'h05, d); xfer(8'hFF, s); desel();
   endtask

   task automatic wren();
      logic [7:0] d;
      sel(); xfer(8'h06, d); desel();
   endtask

   task automatic wrsr(input logic [7:0] v);
      logic [7:0] d;
      sel(); xfer(8'h01, d); xfer(v, d); desel();
   endtask

   task automatic wait_ready();
      logic [7:0] s;
      for (int n = 0; n < 200; n++) begin
         rdsr(s);
         if (!s[0]) break;
      end
   endtask

   task automatic write1(input logic [8:0] a, input logic [7:0] v);
      logic [7:0] d;
      sel(); xfer({4'b0000, a[8], 3'b010}, d); xfer(a[7:0], d); xfer(v, d); desel();
   endtask

   task automatic read1(input logic [8:0] a, output logic [7:0] v);
      logic [7:0] d;
      sel(); xfer({4'b0000, a[8], 3'b011}, d); xfer(a[7:0], d); xfer(8'hFF, v); desel();
   endtask

   task automatic t_reset();
      logic [7:0] s;
      chk("R3 miso idle high after reset", {7'b0, miso}, 8'h01);
      rdsr(s);
      chk("R2 status after reset", s, 8'h00);
   endtask

   task automatic t_enable();
      logic [7:0] s;
      wren();
      rdsr(s);
      chk("R4 latch set by enable", s, 8'h02);
      write1(9'h000, 8'h5A);
      rdsr(s);
      chk("R7 busy and latch cleared", s, 8'h01);
      wait_ready();
      rdsr(s);
      chk("R7 busy ends", s, 8'h00);
   endtask

   task automatic t_page();
      logic [7:0] s, d, v0, v1, v2;
      wren();
      sel(); xfer(8'h0A, d); xfer(8'hFE, d); xfer(8'hAA, d); xfer(8'h55, d); xfer(8'hC3, d); desel();
      rdsr(s);
      chk("R7 busy after page write", s, 8'h01);
      read1(9'h1FE, v0);
      chk("R8 read ignored while busy", v0, 8'hFF);
      wren();
      wait_ready();
      rdsr(s);
      chk("R8 enable ignored while busy", s, 8'h00);
      sel(); xfer(8'h0B, d); xfer(8'hFE, d); xfer(8'hFF, v0); xfer(8'hFF, v1); xfer(8'hFF, v2); desel();
      chk("R3 stream byte 0x1FE", v0, 8'hAA);
      chk("R3 stream byte 0x1FF", v1, 8'h55);
      chk("R3 stream wraps to 0x000", v2, 8'h5A);
      read1(9'h1F0, v0);
      chk("R6 page wrap to 0x1F0", v0, 8'hC3);
      read1(9'h1F1, v0);
      chk("R6 0x1F1 untouched", v0, 8'hFF);
      read1(9'h1FD, v0);
      chk("R6 0x1FD untouched", v0, 8'hFF);
   endtask

   task automatic t_no_latch();
      logic [7:0] s, v;
      write1(9'h010, 8'h12);
      rdsr(s);
      chk("R5 write without latch starts no busy", s, 8'h00);
      read1(9'h010, v);
      chk("R5 write without latch dropped", v, 8'hFF);
      wrsr(8'h0C);
      rdsr(s);
      chk("R5 status write without latch dropped", s, 8'h00);
   endtask

   task automatic t_abort();
      logic [7:0] s, d, v;
      wren();
      sel(); xfer(8'h02, d); xfer(8'h20, d); xfer(8'h34, d); bits(8'hFF, 4, d); desel();
      rdsr(s);
      chk("R10 abort keeps latch, no busy", s, 8'h02);
      read1(9'h020, v);
      chk("R10 abort leaves memory", v, 8'hFF);
   endtask

   task automatic t_unknown();
      logic [7:0] s, d, v;
      sel(); xfer(8'h9F, d); xfer(8'h00, v); desel();
      chk("R1 unknown command keeps miso high", v, 8'hFF);
      sel(); xfer(8'h1B, d); xfer(8'hFE, d); xfer(8'hFF, v); desel();
      chk("R1 read code with upper bits set ignored", v, 8'hFF);
      rdsr(s);
      chk("R1 status unchanged", s, 8'h02);
   endtask

   task automatic t_protect();
      logic [7:0] s, v;
      wrsr(8'hF7);
      rdsr(s);
      chk("R11 status write busy, only bits 3:2", s, 8'h05);
      wait_ready();
      rdsr(s);
      chk("R2 R11 protect field after write", s, 8'h04);
      wren();
      write1(9'h180, 8'h22);
      wait_ready();
      read1(9'h180, v);
      chk("R9 guarded byte 0x180 dropped", v, 8'hFF);
      wren();
      write1(9'h17F, 8'h11);
      wait_ready();
      read1(9'h17F, v);
      chk("R9 unguarded byte 0x17F written", v, 8'h11);
   endtask

   task automatic t_wp();
      logic [7:0] s;
      wr_prot_n = 1'b0;
      idle(HALF);
      wren();
      wrsr(8'h00);
      rdsr(s);
      chk("R11 status write blocked by wr_prot_n", s, 8'h06);
      wr_prot_n = 1'b1;
      idle(HALF);
      wrsr(8'h00);
      wait_ready();
      rdsr(s);
      chk("R11 status write accepted", s, 8'h00);
   endtask

   task automatic t_pause();
      logic [7:0] d, v;
      sel(); xfer(8'h0B, d);
      pause_n = 1'b0;
      idle(HALF);
      for (int k = 0; k < 3; k++) begin
         spi_clk = 1'b1; idle(HALF); spi_clk = 1'b0; idle(HALF);
      end
      pause_n = 1'b1;
      idle(HALF);
      xfer(8'h7F, d); xfer(8'hFF, v); desel();
      chk("R12 clocks during pause ignored", v, 8'h11);
   endtask

   initial begin
      idle(150000);
      errors++;
      $display("FAIL watchdog (all requirements): got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      idle(5);
      rst_n = 1'b1;
      idle(5);
      t_reset();
      t_enable();
      t_page();
      t_no_latch();
      t_abort();
      t_unknown();
      t_protect();
      t_wp();
      t_pause();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule